// File: doc/BRIEF.md
# SD Data Phase Timeout Counter

This block supervises the data phase of an SD/MMC transfer and flags a data timeout when the card stays silent for too long. A data command starts a transfer and marks the data lines active. While the data path reports that it is waiting for a start bit or for busy to release, a counter advances once per SD clock enable tick. Each received data block restarts the count, and so does each new data command. If the count reaches the programmed limit, a sticky timeout flag is raised and the transfer is dropped from the active state. Host software clears the flag by writing a one.

The limit is exponential. A 4-bit select value `n` picks a window of 2^(n+BIAS) counted ticks. BIAS is 13 by default, so the window runs from 8192 ticks up to 2^27 ticks. Values above 14 are treated as 14. The select value is read live, so a change takes effect on the next counted tick.

Top module: `sd_data_timeout`

## Requirements
- R1: After reset, `tmo_flag` and `dat_active` are both 0.
- R2: With `tmo_sel` = n (n from 0 to 14, an unsigned value on bits 3:0), `tmo_flag` is set on the clock edge of the 2^(n+BIAS)-th counted tick after the last restart, and not before.
- R3: A `tmo_sel` value of 15 gives exactly the same window as 14.
- R4: A tick counts only in a cycle where `sd_clk_en`, `data_wait` and `dat_active` are all 1. Any other cycle leaves the count unchanged; it neither advances nor clears it.
- R5: A `blk_rcvd` pulse clears the count to zero, and a tick in the same cycle is not counted.
- R6: A `data_cmd` pulse clears the count to zero and sets `dat_active` on the next edge. It takes precedence over `xfer_end` and over expiry.
- R7: `tmo_flag` stays set until a cycle with `tmo_clr` = 1 and no expiry in that cycle. If expiry and clear happen in the same cycle, the flag stays set.
- R8: `dat_active` falls on the edge after an `xfer_end` pulse or after an expiry, unless `data_cmd` is high in that cycle.
- R9: If `tmo_sel` is lowered while the count already equals or exceeds the new limit minus one, the next counted tick expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_clk_en | input | 1 | One-cycle pulse per SD card clock period |
| data_wait | input | 1 | Data path is waiting for a start bit or for busy to release |
| blk_rcvd | input | 1 | Pulse: a data block was received |
| data_cmd | input | 1 | Pulse: a new data command was issued |
| xfer_end | input | 1 | Pulse: the data transfer completed |
| tmo_sel | input | 4 | Timeout exponent select (window 2^(n+BIAS), 15 treated as 14) |
| tmo_clr | input | 1 | Write-one-to-clear pulse for the timeout flag |
| tmo_flag | output | 1 | Sticky data timeout flag |
| dat_active | output | 1 | Data transfer in progress |

## Verification
A count that is held, cleared or advanced when it should not be shows up as a timeout that comes early or late. A restart that was skipped is the same kind of fault. The error appears at `tmo_flag` and `dat_active` at the latest at the end of the current window, and at the smallest select values that is within a few ticks. The directed tests therefore place the restart and gating events one tick before the limit, so that an error of a single tick flips the flag. A long random run uses short windows and compares both outputs on every cycle.

// File: rtl/sd_tmo_pkg.sv
package sd_tmo_pkg;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned MAX_SEL = 14;

    typedef struct packed {
        logic tout;
        logic act;
    } flag_st_t;
endpackage

// File: rtl/sd_tmo_thresh.sv
module sd_tmo_thresh
    import sd_tmo_pkg::*;
#(
    parameter int unsigned BIAS  = 13,
    parameter int unsigned CNT_W = BIAS + MAX_SEL + 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] term_o
);
    localparam int unsigned EXP_W = $clog2(MAX_SEL + BIAS + 2);

    logic [SEL_W-1:0] eff_sel;
    logic [EXP_W-1:0] exp_w;

    always_comb begin
        eff_sel = (sel_i > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel_i;
        exp_w   = EXP_W'(eff_sel) + EXP_W'(BIAS);
    end

    // terminal count is 2^exp - 1: all bits below the exponent set
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_term
        assign term_o[gi] = (EXP_W'(gi) < exp_w);
    end
endmodule

// File: rtl/sd_tmo_counter.sv
module sd_tmo_counter #(
    parameter int unsigned CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d     = st_q;
        hit      = (st_q.cnt >= term_i);
        expire_o = 1'b0;
        if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (hit) begin
                st_d.cnt = '0;
                expire_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/sd_tmo_flags.sv
module sd_tmo_flags
    import sd_tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic end_i,
    input  logic expire_i,
    input  logic clr_i,
    output logic tout_o,
    output logic act_o
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire_i)   st_d.tout = 1'b1;
        else if (clr_i) st_d.tout = 1'b0;
        if (cmd_i)                     st_d.act = 1'b1;
        else if (end_i || expire_i)    st_d.act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tout_o = st_q.tout;
    assign act_o  = st_q.act;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tout && !clr_i) |=> st_q.tout);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> !st_q.tout);

    // R6
    act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i |=> st_q.act);

    // R8
    act_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i && (end_i || expire_i)) |=> !st_q.act);
endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout
    import sd_tmo_pkg::*;
#(
    parameter int unsigned BIAS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_clk_en,
    input  logic             data_wait,
    input  logic             blk_rcvd,
    input  logic             data_cmd,
    input  logic             xfer_end,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             tmo_clr,
    output logic             tmo_flag,
    output logic             dat_active
);
    localparam int unsigned CNT_W = BIAS + MAX_SEL + 1;

    logic [CNT_W-1:0] term;
    logic             tick;
    logic             restart;
    logic             expire;

    assign tick    = sd_clk_en && data_wait && dat_active;
    assign restart = blk_rcvd || data_cmd;

    sd_tmo_thresh #(.BIAS(BIAS), .CNT_W(CNT_W)) u_thresh (
        .sel_i  (tmo_sel),
        .term_o (term)
    );

    sd_tmo_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .restart_i (restart),
        .term_i    (term),
        .expire_o  (expire)
    );

    sd_tmo_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (data_cmd),
        .end_i    (xfer_end),
        .expire_i (expire),
        .clr_i    (tmo_clr),
        .tout_o   (tmo_flag),
        .act_o    (dat_active)
    );

    // R2
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(tick && !restart));
endmodule

// File: tb/tb_sd_data_timeout.sv
module tb_sd_data_timeout;
    localparam int unsigned BIAS = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sd_clk_en = 1'b0, data_wait = 1'b0, blk_rcvd = 1'b0;
    logic       data_cmd = 1'b0, xfer_end = 1'b0, tmo_clr = 1'b0;
    logic [3:0] tmo_sel = 4'd0;
    logic       tmo_flag, dat_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sd_data_timeout #(.BIAS(BIAS)) dut (
        .clk(clk), .rst_n(rst_n), .sd_clk_en(sd_clk_en), .data_wait(data_wait),
        .blk_rcvd(blk_rcvd), .data_cmd(data_cmd), .xfer_end(xfer_end),
        .tmo_sel(tmo_sel), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag),
        .dat_active(dat_active)
    );

    function automatic longint win(input logic [3:0] n);
        int e;
        e = (n > 4'd14) ? 14 : int'(n);
        return longint'(1) << (e + BIAS);
    endfunction

    // reference model built from the requirements
    longint m_cnt = 0;
    bit     m_flag = 1'b0, m_act = 1'b0;
    always @(posedge clk or negedge rst_n) begin
        bit exp_now;
        if (!rst_n) begin
            m_cnt = 0; m_flag = 1'b0; m_act = 1'b0;
        end else begin
            exp_now = 1'b0;
            if (blk_rcvd || data_cmd) m_cnt = 0;
            else if (sd_clk_en && data_wait && m_act) begin
                if (m_cnt >= win(tmo_sel) - 1) begin m_cnt = 0; exp_now = 1'b1; end
                else m_cnt = m_cnt + 1;
            end
            if (exp_now) m_flag = 1'b1; else if (tmo_clr) m_flag = 1'b0;
            if (data_cmd) m_act = 1'b1; else if (xfer_end || exp_now) m_act = 1'b0;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp_v);
        end
    endtask

    task automatic ticks(input longint k);
        @(negedge clk); sd_clk_en = 1'b1; data_wait = 1'b1;
        repeat (k) @(negedge clk);
        sd_clk_en = 1'b0; data_wait = 1'b0;
    endtask

    task automatic cmd_pulse();
        @(negedge clk); data_cmd = 1'b1;
        @(negedge clk); data_cmd = 1'b0;
    endtask

    task automatic blk_pulse();
        @(negedge clk); blk_rcvd = 1'b1;
        @(negedge clk); blk_rcvd = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk); tmo_clr = 1'b1;
        @(negedge clk); tmo_clr = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flag", tmo_flag, 1'b0);
        chk("R1 active", dat_active, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 smallest window: 2 ticks
        tmo_sel = 4'd0; cmd_pulse();
        chk("R6 active set", dat_active, 1'b1);
        ticks(1); chk("R2 early", tmo_flag, 1'b0);
        ticks(1); chk("R2 expire", tmo_flag, 1'b1);
        chk("R8 active drop on expiry", dat_active, 1'b0);
        repeat (5) @(negedge clk);
        chk("R7 sticky", tmo_flag, 1'b1);
        clr_pulse(); chk("R7 cleared", tmo_flag, 1'b0);

        // R7 expiry and clear together: set wins
        cmd_pulse(); ticks(1);
        @(negedge clk); sd_clk_en = 1'b1; data_wait = 1'b1; tmo_clr = 1'b1;
        @(negedge clk); sd_clk_en = 1'b0; data_wait = 1'b0; tmo_clr = 1'b0;
        chk("R7 set beats clear", tmo_flag, 1'b1);
        clr_pulse();

        // R4 gating: window 4
        tmo_sel = 4'd1; cmd_pulse(); ticks(3);
        @(negedge clk); sd_clk_en = 1'b0; data_wait = 1'b1;
        repeat (10) @(negedge clk);
        sd_clk_en = 1'b1; data_wait = 1'b0;
        repeat (10) @(negedge clk);
        sd_clk_en = 1'b0;
        chk("R4 held no expiry", tmo_flag, 1'b0);
        ticks(1); chk("R4 count kept", tmo_flag, 1'b1);
        clr_pulse();

        // R5 block restart
        cmd_pulse(); ticks(3); blk_pulse(); ticks(3);
        chk("R5 restarted", tmo_flag, 1'b0);
        ticks(1); chk("R5 expire after restart", tmo_flag, 1'b1);
        clr_pulse();

        // R6 command restart
        cmd_pulse(); ticks(3); cmd_pulse(); ticks(3);
        chk("R6 restarted", tmo_flag, 1'b0);
        ticks(1); chk("R6 expire after restart", tmo_flag, 1'b1);
        clr_pulse();

        // R8 transfer end stops counting
        cmd_pulse();
        @(negedge clk); xfer_end = 1'b1;
        @(negedge clk); xfer_end = 1'b0;
        chk("R8 active drop on end", dat_active, 1'b0);
        ticks(20); chk("R8 no count when inactive", tmo_flag, 1'b0);

        // R9 lowering the select mid-count
        tmo_sel = 4'd3; cmd_pulse(); ticks(5);
        chk("R9 before change", tmo_flag, 1'b0);
        tmo_sel = 4'd1; ticks(1);
        chk("R9 next tick expires", tmo_flag, 1'b1);
        clr_pulse();

        // R2 largest window, R3 clamp
        tmo_sel = 4'd14; cmd_pulse(); ticks(win(4'd14) - 1);
        chk("R2 max early", tmo_flag, 1'b0);
        ticks(1); chk("R2 max expire", tmo_flag, 1'b1);
        clr_pulse();
        tmo_sel = 4'd15; cmd_pulse(); ticks(win(4'd14) - 1);
        chk("R3 clamp early", tmo_flag, 1'b0);
        ticks(1); chk("R3 clamp expire", tmo_flag, 1'b1);
        clr_pulse();

        // random phase against the model (R2, R4 to R8)
        void'($urandom(32'd4242));
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R2 random flag", tmo_flag, m_flag);
            chk("R8 random active", dat_active, m_act);
            sd_clk_en = ($urandom_range(0, 3) != 0);
            data_wait = ($urandom_range(0, 7) != 0);
            blk_rcvd  = ($urandom_range(0, 15) == 0);
            data_cmd  = ($urandom_range(0, 19) == 0);
            xfer_end  = ($urandom_range(0, 39) == 0);
            tmo_clr   = ($urandom_range(0, 9) == 0);
            tmo_sel   = 4'($urandom_range(0, 3));
        end
        @(negedge clk);
        chk("R2 random final", tmo_flag, m_flag);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule